// File: doc/BRIEF.md
# Interrupt Redirection Controller

This block routes a set of interrupt input pins to interrupt messages. Every pin owns a 64-bit redirection entry that holds its vector, delivery mode, destination mode, trigger mode, mask and destination. Software does not see the entries directly. It first writes a register index into a select register, then reads or writes the chosen 32-bit register through a data window on a simple 32-bit memory-mapped bus. Besides the entries, that window also reaches an identification register and a read-only version register.

When a pin fires, the block builds a message from the pin's entry and holds it in an output register that uses a valid/ready handshake. The message carries the vector, a 15-bit destination, the delivery mode, the destination mode and a level flag. Edge-triggered pins fire once for each rising input. Level-triggered pins fire while they are asserted, and each delivery sets a remote-pending bit. That bit blocks any further delivery from the pin until an end-of-interrupt arrives with the same vector. Inputs are synchronous to the clock.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every entry reads 0x00010000 in both its low and its high word (pin masked), the select register reads 0, and no message is valid.
- R2: Register index 0x01 reads ((NPINS-1) << 16) | 0x11, which is 0x00170011 for 24 pins, and writes to it have no effect.
- R3: Register index 0x00 is the identification register. Only bits 27:24 are writable. All of its other bits read 0.
- R4: Bus byte offset 0x00 is the select register (bits 7:0) and offset 0x10 is the data window. Reads use the offset alone. Other offsets read 0 and ignore writes. Index 0x10+2p reaches the low word of pin p's entry and index 0x11+2p its high word. Indices with no register read 0.
- R5: Low-word layout: vector 7:0, delivery mode 10:8, destination mode 11, delivery status 12 (reads 0), polarity 13 (stored only), remote-pending 14, trigger 15 (1 = level), mask 16. Bits 12, 14 and 31:17 are not changed by writes. A write of 0xFFFFFFFF reads back 0x0001AFFF.
- R6: A pin with its mask bit set never delivers, whatever its input does.
- R7: An unmasked edge-triggered pin delivers exactly one message for each low-to-high transition of its input.
- R8: A level-triggered delivery sets the pin's remote-pending bit. While that bit is set the pin does not deliver again.
- R9: An end-of-interrupt with vector V clears remote-pending on every pin whose bit is set and whose vector equals V. A pin that is still asserted then delivers again. A non-matching vector changes nothing.
- R10: A write that leaves an entry in edge mode clears its remote-pending bit.
- R11: After an entry write leaves a pin level-triggered, unmasked and asserted with remote-pending clear, the pin delivers.
- R12: Message fields: the vector, delivery mode and destination mode come from the low word. The level flag equals the trigger bit. The destination is {high[23:17], high[31:24]}.
- R13: A valid message stays unchanged until it is accepted. When several pins request at once, the lowest-numbered pin goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NPINS | Interrupt input levels, active high |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high |
| bus_off | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_off |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector being completed |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 15 | Message destination |
| msg_delmode | output | 3 | Message delivery mode |
| msg_destmode | output | 1 | Message destination mode |
| msg_level | output | 1 | Message came from a level-triggered pin |

## Verification
The properties assume that the consumer never withdraws a pending message and that pin inputs and end-of-interrupt strobes change only between clock edges. The bench therefore drives every input on the falling edge. It holds msg_ready low while it inspects a message, then raises it for exactly one cycle to accept. End-of-interrupt strobes last a single cycle, and the bench issues them only for vectors it has programmed, so each remote-pending state it reads back follows from its own earlier writes.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  // Bus byte offsets
  localparam logic [4:0] OFF_SELECT = 5'h00;
  localparam logic [4:0] OFF_WINDOW = 5'h10;

  // Register indices reached through the window
  localparam logic [7:0] IDX_IDENT   = 8'h00;
  localparam logic [7:0] IDX_VERSION = 8'h01;

  // Low word bit positions
  localparam int BIT_PEND = 14;
  localparam int BIT_TRIG = 15;
  localparam int BIT_MASK = 16;

  localparam logic [31:0] LO_WR_MASK = 32'h0001_AFFF;
  localparam logic [31:0] LO_RESET   = 32'h0001_0000;
  localparam logic [31:0] HI_RESET   = 32'h0001_0000;

  localparam int ID_LSB = 24;
  localparam int ID_W   = 4;

  typedef struct packed {
    logic [7:0]  vector;
    logic [14:0] dest;
    logic [2:0]  delmode;
    logic        destmode;
    logic        level;
  } irq_msg_t;

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NPINS      = 24,
  parameter int SEL_W      = 8,
  parameter int REDIR_BASE = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_en,
  input  logic                   bus_we,
  input  logic [4:0]             bus_off,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NPINS-1:0]       load_vec,
  input  logic                   eoi_valid,
  input  logic [7:0]             eoi_vector,
  output logic [NPINS-1:0][31:0] ent_lo,
  output logic [NPINS-1:0][31:0] ent_hi,
  output logic [NPINS-1:0]       pend_vec
);

  localparam int          PO_W      = SEL_W - 1;
  localparam int          REDIR_END = REDIR_BASE + 2 * NPINS;
  localparam logic [31:0] VER_VAL   = (32'(NPINS - 1) << 16) | 32'h0000_0011;

  logic [SEL_W-1:0]       sel_q, sel_d;
  logic                   sel_we;
  logic [ID_W-1:0]        id_q, id_d;
  logic                   id_we;
  logic [NPINS-1:0][31:0] lo_q, hi_q;
  logic [NPINS-1:0]       lo_we, hi_we;
  logic [NPINS-1:0]       pend_q, pend_d;
  logic [31:0]            lo_wd;
  logic                   win_wr;
  logic                   in_redir;
  logic [SEL_W-1:0]       rel_idx;
  logic [PO_W-1:0]        pin_off;
  logic                   hi_half;
  logic [31:0]            win_rd;

  // Decode of the select register
  assign win_wr   = bus_en & bus_we & (bus_off == OFF_WINDOW);
  assign sel_we   = bus_en & bus_we & (bus_off == OFF_SELECT);
  assign sel_d    = bus_wdata[SEL_W-1:0];
  assign in_redir = (int'(sel_q) >= REDIR_BASE) && (int'(sel_q) < REDIR_END);
  assign rel_idx  = sel_q - SEL_W'(REDIR_BASE);
  assign pin_off  = rel_idx[SEL_W-1:1];
  assign hi_half  = rel_idx[0];
  assign lo_wd    = bus_wdata & LO_WR_MASK;
  assign id_we    = win_wr & (sel_q == IDX_IDENT);
  assign id_d     = bus_wdata[ID_LSB +: ID_W];

  // Per-pin write enables and remote-pending next state
  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      logic trig_next;
      lo_we[i]  = win_wr & in_redir & (pin_off == PO_W'(i)) & ~hi_half;
      hi_we[i]  = win_wr & in_redir & (pin_off == PO_W'(i)) & hi_half;
      trig_next = lo_we[i] ? lo_wd[BIT_TRIG] : lo_q[i][BIT_TRIG];
      pend_d[i] = pend_q[i];
      if (load_vec[i] && lo_q[i][BIT_TRIG]) begin
        pend_d[i] = 1'b1;
      end
      if (eoi_valid && pend_q[i] && (lo_q[i][7:0] == eoi_vector)) begin
        pend_d[i] = 1'b0;
      end
      if (!trig_next) begin
        pend_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      id_q   <= '0;
      pend_q <= '0;
      for (int i = 0; i < NPINS; i++) begin
        lo_q[i] <= LO_RESET;
        hi_q[i] <= HI_RESET;
      end
    end else begin
      if (sel_we) sel_q <= sel_d;
      if (id_we)  id_q  <= id_d;
      pend_q <= pend_d;
      for (int i = 0; i < NPINS; i++) begin
        if (lo_we[i]) lo_q[i] <= lo_wd;
        if (hi_we[i]) hi_q[i] <= bus_wdata;
      end
    end
  end

  // Read path through the window
  always_comb begin
    win_rd = '0;
    if (sel_q == IDX_IDENT) begin
      win_rd = 32'(id_q) << ID_LSB;
    end else if (sel_q == IDX_VERSION) begin
      win_rd = VER_VAL;
    end else if (in_redir) begin
      for (int i = 0; i < NPINS; i++) begin
        if (pin_off == PO_W'(i)) begin
          win_rd = hi_half ? hi_q[i] : (lo_q[i] | (32'(pend_q[i]) << BIT_PEND));
        end
      end
    end
  end

  always_comb begin
    case (bus_off)
      OFF_SELECT: bus_rdata = 32'(sel_q);
      OFF_WINDOW: bus_rdata = win_rd;
      default:    bus_rdata = '0;
    endcase
  end

  assign ent_lo   = lo_q;
  assign ent_hi   = hi_q;
  assign pend_vec = pend_q;

endmodule

// File: rtl/irq_route_pins.sv
module irq_route_pins #(
  parameter int NPINS = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_in,
  input  logic [NPINS-1:0] lvl_vec,
  input  logic [NPINS-1:0] mask_vec,
  input  logic [NPINS-1:0] pend_vec,
  input  logic [NPINS-1:0] load_vec,
  output logic [NPINS-1:0] req,
  output logic [NPINS-1:0] edge_pend
);

  logic [NPINS-1:0] irq_q;
  logic [NPINS-1:0] epend_q, epend_d;
  logic [NPINS-1:0] rise;

  assign rise = irq_in & ~irq_q;

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    always_comb begin
      epend_d[g] = epend_q[g];
      if (load_vec[g]) epend_d[g] = 1'b0;
      if (rise[g])     epend_d[g] = 1'b1;
      if (mask_vec[g] || lvl_vec[g]) epend_d[g] = 1'b0;
    end

    assign req[g] = (epend_q[g] & ~mask_vec[g] & ~lvl_vec[g]) |
                    (lvl_vec[g] & irq_in[g] & ~mask_vec[g] & ~pend_vec[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q   <= '0;
      epend_q <= '0;
    end else begin
      irq_q   <= irq_in;
      epend_q <= epend_d;
    end
  end

  assign edge_pend = epend_q;

endmodule

// File: rtl/irq_route_arb.sv
module irq_route_arb #(
  parameter int NPINS = 24
) (
  input  logic [NPINS-1:0] req,
  output logic [NPINS-1:0] grant,
  output logic             any
);

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    any = found;
  end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NPINS      = 24,
  parameter int REDIR_BASE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] irq_in,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [4:0]       bus_off,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [7:0]       msg_vector,
  output logic [14:0]      msg_dest,
  output logic [2:0]       msg_delmode,
  output logic             msg_destmode,
  output logic             msg_level
);

  localparam int SEL_W = 8;

  logic [NPINS-1:0][31:0] ent_lo, ent_hi;
  logic [NPINS-1:0]       pend_vec, lvl_vec, mask_vec;
  logic [NPINS-1:0]       req, grant, load_vec, edge_pend;
  logic                   any;
  logic                   load_en;
  irq_msg_t               cand, msg_q;
  logic                   valid_q, valid_d;

  irq_route_regs #(
    .NPINS(NPINS), .SEL_W(SEL_W), .REDIR_BASE(REDIR_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .load_vec(load_vec), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .pend_vec(pend_vec)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_vec
    assign lvl_vec[g]  = ent_lo[g][BIT_TRIG];
    assign mask_vec[g] = ent_lo[g][BIT_MASK];
  end

  irq_route_pins #(.NPINS(NPINS)) u_pins (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .lvl_vec(lvl_vec), .mask_vec(mask_vec), .pend_vec(pend_vec),
    .load_vec(load_vec), .req(req), .edge_pend(edge_pend)
  );

  irq_route_arb #(.NPINS(NPINS)) u_arb (
    .req(req), .grant(grant), .any(any)
  );

  assign load_en  = any & (~valid_q | msg_ready);
  assign load_vec = grant & {NPINS{load_en}};

  // One-hot select of the granted entry
  always_comb begin
    cand = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (grant[i]) begin
        cand.vector   = cand.vector   | ent_lo[i][7:0];
        cand.delmode  = cand.delmode  | ent_lo[i][10:8];
        cand.destmode = cand.destmode | ent_lo[i][11];
        cand.level    = cand.level    | ent_lo[i][BIT_TRIG];
        cand.dest     = cand.dest     | {ent_hi[i][23:17], ent_hi[i][31:24]};
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (load_en) begin
      valid_d = 1'b1;
    end else if (msg_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (load_en) msg_q <= cand;
    end
  end

  assign msg_valid    = valid_q;
  assign msg_vector   = msg_q.vector;
  assign msg_dest     = msg_q.dest;
  assign msg_delmode  = msg_q.delmode;
  assign msg_destmode = msg_q.destmode;
  assign msg_level    = msg_q.level;

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [7:0]       msg_vector,
  input logic [14:0]      msg_dest,
  input logic [2:0]       msg_delmode,
  input logic             msg_destmode,
  input logic             msg_level,
  input logic             load_en,
  input logic [NPINS-1:0] grant,
  input logic [NPINS-1:0] req,
  input logic [NPINS-1:0] lvl_vec,
  input logic [NPINS-1:0] mask_vec,
  input logic [NPINS-1:0] pend_vec,
  input logic [NPINS-1:0] edge_pend
);

  p_msg_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid &&
      $stable({msg_vector, msg_dest, msg_delmode, msg_destmode, msg_level})))
    else $error("held message changed");

  p_lowest_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> ($onehot0(grant) && ((req & (grant - 1'b1)) == '0)))
    else $error("grant not lowest requester");

  p_masked_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant & mask_vec) == '0) && ((edge_pend & mask_vec) == '0))
    else $error("masked pin requested");

  p_no_redeliver_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & lvl_vec & pend_vec) == '0)
    else $error("level pin granted while pending");

  p_pend_level_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & ~lvl_vec) == '0)
    else $error("remote-pending on edge pin");

  p_level_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (msg_valid && (msg_level == $past(|(grant & lvl_vec)))))
    else $error("level flag mismatch");

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_delmode(msg_delmode),
  .msg_destmode(msg_destmode), .msg_level(msg_level),
  .load_en(load_en), .grant(grant), .req(req),
  .lvl_vec(lvl_vec), .mask_vec(mask_vec), .pend_vec(pend_vec),
  .edge_pend(edge_pend)
);

// File: tb/test_irq_route_ctrl.sv
module test_irq_route_ctrl;

  localparam int NPINS = 24;

  logic             clk;
  logic             rst_n;
  logic [NPINS-1:0] irq_in;
  logic             bus_en, bus_we;
  logic [4:0]       bus_off;
  logic [31:0]      bus_wdata, bus_rdata;
  logic             eoi_valid;
  logic [7:0]       eoi_vector;
  logic             msg_valid, msg_ready;
  logic [7:0]       msg_vector;
  logic [14:0]      msg_dest;
  logic [2:0]       msg_delmode;
  logic             msg_destmode, msg_level;

  int checks = 0;
  int errors = 0;

  irq_route_ctrl #(.NPINS(NPINS)) i_irq_route_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_en(bus_en), .bus_we(bus_we), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest), .msg_delmode(msg_delmode),
    .msg_destmode(msg_destmode), .msg_level(msg_level)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] off, input logic [31:0] data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_off = off; bus_wdata = data;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] off, output logic [31:0] data);
    @(negedge clk);
    bus_off = off;
    #1 data = bus_rdata;
  endtask

  task automatic reg_write(input logic [7:0] idx, input logic [31:0] data);
    bus_write(5'h00, 32'(idx));
    bus_write(5'h10, data);
  endtask

  task automatic reg_read(input logic [7:0] idx, output logic [31:0] data);
    bus_write(5'h00, 32'(idx));
    bus_read(5'h10, data);
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic set_irq(input int pin, input logic val);
    @(negedge clk);
    irq_in[pin] = val;
  endtask

  task automatic expect_msg(input string tag, input logic [7:0] vec, input logic [14:0] dest,
                            input logic [2:0] dm, input logic dmode, input logic lvl);
    int w;
    w = 0;
    while (!msg_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    check32({tag, " msg"},
            {4'h0, msg_valid, msg_vector, msg_dest, msg_delmode, msg_destmode, msg_level},
            {4'h0, 1'b1, vec, dest, dm, dmode, lvl});
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic expect_none(input string tag, input int n);
    logic seen;
    seen = 1'b0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (msg_valid) seen = 1'b1;
    end
    check32({tag, " no msg"}, 32'(seen), 32'h0);
  endtask

  // R1, R2
  task automatic t_reset();
    logic [31:0] d;
    check32("R1 valid after reset", 32'(msg_valid), 32'h0);
    bus_read(5'h00, d);
    check32("R1 select after reset", d, 32'h0);
    reg_read(8'h10, d);
    check32("R1 entry0 low", d, 32'h0001_0000);
    reg_read(8'h3F, d);
    check32("R1 entry23 high", d, 32'h0001_0000);
    reg_read(8'h01, d);
    check32("R2 version", d, 32'h0017_0011);
    bus_write(5'h10, 32'hFFFF_FFFF);
    bus_read(5'h10, d);
    check32("R2 version write ignored", d, 32'h0017_0011);
  endtask

  // R3
  task automatic t_ident();
    logic [31:0] d;
    reg_write(8'h00, 32'hFFFF_FFFF);
    reg_read(8'h00, d);
    check32("R3 id field", d, 32'h0F00_0000);
  endtask

  // R4
  task automatic t_window();
    logic [31:0] d;
    reg_write(8'h17, 32'h1234_5678);
    bus_read(5'h00, d);
    check32("R4 select readback", d, 32'h0000_0017);
    bus_read(5'h10, d);
    check32("R4 pin3 high word", d, 32'h1234_5678);
    reg_read(8'h16, d);
    check32("R4 pin3 low word", d, 32'h0001_0000);
    bus_write(5'h00, 32'h17);
    bus_write(5'h08, 32'hDEAD_BEEF);
    bus_read(5'h10, d);
    check32("R4 stray write ignored", d, 32'h1234_5678);
    bus_read(5'h08, d);
    check32("R4 stray offset reads 0", d, 32'h0);
    reg_read(8'h40, d);
    check32("R4 unused index reads 0", d, 32'h0);
  endtask

  // R5
  task automatic t_readonly();
    logic [31:0] d;
    reg_write(8'h12, 32'hFFFF_FFFF);
    reg_read(8'h12, d);
    check32("R5 read-only bits", d, 32'h0001_AFFF);
    reg_write(8'h12, 32'h0001_0000);
  endtask

  // R6
  task automatic t_masked();
    reg_write(8'h14, 32'h0001_0030);
    set_irq(2, 1'b1);
    expect_none("R6 masked edge pin", 8);
    set_irq(2, 1'b0);
    expect_none("R6 masked edge fall", 3);
  endtask

  // R7, R12
  task automatic t_edge();
    reg_write(8'h15, 32'h0500_0000);
    reg_write(8'h14, 32'h0000_0031);
    set_irq(2, 1'b1);
    expect_msg("R7 first rise", 8'h31, 15'h0005, 3'd0, 1'b0, 1'b0);
    expect_none("R7 held high", 8);
    set_irq(2, 1'b0);
    set_irq(2, 1'b1);
    expect_msg("R7 second rise", 8'h31, 15'h0005, 3'd0, 1'b0, 1'b0);
    set_irq(2, 1'b0);
    reg_write(8'h19, 32'hAB00_0000 | (32'h5A << 17));
    reg_write(8'h18, 32'h0000_0B44);
    set_irq(4, 1'b1);
    expect_msg("R12 field mapping", 8'h44, 15'h5AAB, 3'd3, 1'b1, 1'b0);
    set_irq(4, 1'b0);
  endtask

  // R8, R9
  task automatic t_level();
    logic [31:0] d;
    reg_write(8'h1B, 32'h0100_0000);
    reg_write(8'h1A, 32'h0000_8050);
    set_irq(5, 1'b1);
    expect_msg("R8 level delivery", 8'h50, 15'h0001, 3'd0, 1'b0, 1'b1);
    reg_read(8'h1A, d);
    check32("R8 pending set", d, 32'h0000_C050);
    expect_none("R8 no redelivery", 6);
    eoi(8'h51);
    expect_none("R9 wrong vector", 4);
    reg_read(8'h1A, d);
    check32("R9 wrong vector keeps pending", d, 32'h0000_C050);
    eoi(8'h50);
    expect_msg("R9 redeliver", 8'h50, 15'h0001, 3'd0, 1'b0, 1'b1);
    set_irq(5, 1'b0);
    eoi(8'h50);
    expect_none("R9 deasserted after eoi", 4);
    reg_read(8'h1A, d);
    check32("R9 pending cleared", d, 32'h0000_8050);
  endtask

  // R10
  task automatic t_to_edge();
    logic [31:0] d;
    set_irq(5, 1'b1);
    expect_msg("R10 level setup", 8'h50, 15'h0001, 3'd0, 1'b0, 1'b1);
    reg_write(8'h1A, 32'h0000_0050);
    reg_read(8'h1A, d);
    check32("R10 edge write clears pending", d, 32'h0000_0050);
    expect_none("R10 no rise no msg", 4);
    set_irq(5, 1'b0);
    reg_write(8'h1A, 32'h0001_0050);
  endtask

  // R11
  task automatic t_write_delivers();
    reg_write(8'h1C, 32'h0001_8060);
    set_irq(6, 1'b1);
    expect_none("R11 masked level", 6);
    reg_write(8'h1C, 32'h0000_8060);
    expect_msg("R11 unmask delivers", 8'h60, 15'h0000, 3'd0, 1'b0, 1'b1);
    set_irq(6, 1'b0);
    eoi(8'h60);
  endtask

  // R13
  task automatic t_priority();
    reg_write(8'h1E, 32'h0000_0070);
    reg_write(8'h20, 32'h0000_0080);
    @(negedge clk);
    irq_in[7] = 1'b1;
    irq_in[8] = 1'b1;
    repeat (3) @(negedge clk);
    check32("R13 lowest pin first", {23'h0, msg_valid, msg_vector}, {23'h0, 1'b1, 8'h70});
    repeat (5) @(negedge clk);
    check32("R13 held while not ready", {23'h0, msg_valid, msg_vector}, {23'h0, 1'b1, 8'h70});
    expect_msg("R13 accept first", 8'h70, 15'h0000, 3'd0, 1'b0, 1'b0);
    expect_msg("R13 second pin", 8'h80, 15'h0000, 3'd0, 1'b0, 1'b0);
    expect_none("R13 nothing left", 4);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; irq_in = '0;
    bus_en = 1'b0; bus_we = 1'b0; bus_off = '0; bus_wdata = '0;
    eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_window();
    t_readonly();
    t_masked();
    t_edge();
    t_level();
    t_to_edge();
    t_write_delivers();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule